// File: doc/BRIEF.md
# Sampling-Point Tuning Window Search

This block is a hardware sequencer that picks the receive sampling delay for the 200 MHz single-data-rate eMMC speed mode. On a start request it walks a delay-line tap code upward from zero. For each code it hands the value to the delay line and holds an update request until the line confirms the change. It then asks an external checker to run a tuning-block transfer and records whether the transfer passed.

While sweeping, it tracks the length of the current run of passing taps and the longest run seen so far, together with the last tap of that longest run. After the last code it moves the delay line to the middle of the best run and reports completion. If no code passed, it reports an error instead and does not move the delay line. A start request made in any other speed mode is turned back at once with an error.

Only the codes below `TAP_COUNT` (default 40) are swept, although the tap field is 6 bits wide. Codes at about 43 and above alias back onto low delays, so a margin below that point is kept. The delay line may fail to confirm an update. A cycle timeout covers that case and counts the tap as failing.

Top module: `tap_window_tuner`

## Requirements
- R1: After an accepted start, taps 0 to TAP_COUNT-1 are applied in ascending order. For each tap, `tapUpdate` stays high with a stable `tapValue` until the cycle in which `tapReady` is sampled high.
- R2: `chkReq` rises only in the cycle after a tap update is confirmed, and stays high until `chkAck`. `chkPass` is sampled in the `chkAck` cycle; 1 means pass.
- R3: If `tapReady` does not arrive within TIMEOUT_CYC cycles of the update request, the update is withdrawn and the tap counts as failing. No check is requested for that tap.
- R4: A failing tap resets the current run length to zero. The best run is replaced only by a strictly longer run, so the earliest of equally long runs wins.
- R5: After the sweep, the tap equal to (last tap of best run) minus floor(best length / 2) is applied through the same update handshake. In the cycle after its confirmation, `done` is high and `err` is low, with that tap on `tapValue`.
- R6: If no tap passed, `done` and `err` are high together in one cycle and no further tap update is made.
- R7: `speedMode` is a 3-bit code: 0 SD, 2 MMC SDR, 3 MMC DDR, 4 HS200, 5 HS400. A start with any code other than 4 gives `done` and `err` together without any tap update or check request.
- R8: `start` is ignored while a search is in progress. Exactly one `done` pulse follows one accepted start.
- R9: After reset, `done`, `err`, `tapUpdate` and `chkReq` are low and `tapValue` is 0.
- R10: `done` is high for exactly one cycle, `err` is high only with `done`, and `tapUpdate` and `chkReq` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a search (sampled in idle only) |
| speedMode | input | 3 | Current bus speed mode code |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Search failed or was rejected; valid with done |
| tapValue | output | TAP_W | Delay tap code presented to the delay line |
| tapUpdate | output | 1 | Update request, held until confirmed or timed out |
| tapReady | input | 1 | Delay line confirms the update |
| chkReq | output | 1 | Tuning-block check request, held until acknowledged |
| chkAck | input | 1 | Check finished |
| chkPass | input | 1 | Check result, valid with chkAck |

## Verification
The properties assume that `tapReady` and `chkAck` are one-cycle pulses that arrive only while the matching request is high. They also assume that `chkPass` matters only in the `chkAck` cycle. The bench's delay-line and checker models respond only to a live request, after a random latency. Each model drops its response on the next cycle. The models either never answer a tap marked as stalled, or answer within a latency well inside the timeout. Pass patterns and stall masks are drawn from a seeded generator, with directed cases for tied windows, edge taps, the all-pass case and the all-fail case.

// File: rtl/tap_tune_pkg.sv
package tap_tune_pkg;

  localparam logic [2:0] MODE_HS200 = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_CHECK,
    ST_STEP,
    ST_FIN_APPLY,
    ST_OK,
    ST_FAIL
  } tuneState_t;

  typedef struct packed {
    logic initSweep;
    logic markPass;
    logic markFail;
    logic advance;
    logic loadFinal;
    logic timerClr;
  } tuneCtrl_t;

endpackage

// File: rtl/tap_tune_datapath.sv
module tap_tune_datapath
  import tap_tune_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int TAP_COUNT   = 40,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tuneCtrl_t        ctrl,
  output logic [TAP_W-1:0] tapIdx,
  output logic             lastTap,
  output logic             anyPass,
  output logic             timeout
);

  localparam int CNT_W = $clog2(TAP_COUNT + 1);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TAP_W-1:0] LAST_IDX = TAP_W'(TAP_COUNT - 1);
  localparam logic [TMR_W-1:0] TMR_LIMIT = TMR_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] runLen;
  logic [CNT_W-1:0] bestLen;
  logic [TAP_W-1:0] bestEnd;
  logic [TMR_W-1:0] timer;
  logic [CNT_W-1:0] runNext;
  logic [TAP_W-1:0] centreTap;

  assign runNext   = runLen + 1'b1;
  assign centreTap = bestEnd - TAP_W'(bestLen >> 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tapIdx  <= '0;
      runLen  <= '0;
      bestLen <= '0;
      bestEnd <= '0;
    end else begin
      if (ctrl.initSweep) begin
        tapIdx  <= '0;
        runLen  <= '0;
        bestLen <= '0;
        bestEnd <= '0;
      end
      if (ctrl.markFail) begin
        runLen <= '0;
      end
      if (ctrl.markPass) begin
        runLen <= runNext;
        if (runNext > bestLen) begin
          bestLen <= runNext;
          bestEnd <= tapIdx;
        end
      end
      if (ctrl.advance) begin
        tapIdx <= tapIdx + 1'b1;
      end
      if (ctrl.loadFinal) begin
        tapIdx <= centreTap;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.timerClr) begin
      timer <= '0;
    end else if (timer != TMR_LIMIT) begin
      timer <= timer + 1'b1;
    end
  end

  assign lastTap = (tapIdx == LAST_IDX);
  assign anyPass = (bestLen != '0);
  assign timeout = (timer == TMR_LIMIT);

endmodule

// File: rtl/tap_tune_control.sv
module tap_tune_control
  import tap_tune_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] speedMode,
  input  logic       tapReady,
  input  logic       chkAck,
  input  logic       chkPass,
  input  logic       lastTap,
  input  logic       anyPass,
  input  logic       timeout,
  output tuneCtrl_t  ctrl,
  output logic       tapUpdate,
  output logic       chkReq,
  output logic       done,
  output logic       err
);

  tuneState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (speedMode == MODE_HS200) begin
            ctrl.initSweep = 1'b1;
            ctrl.timerClr  = 1'b1;
            stateNext      = ST_APPLY;
          end else begin
            stateNext = ST_FAIL;
          end
        end
      end
      ST_APPLY: begin
        if (tapReady) begin
          stateNext = ST_CHECK;
        end else if (timeout) begin
          ctrl.markFail = 1'b1;
          stateNext     = ST_STEP;
        end
      end
      ST_CHECK: begin
        if (chkAck) begin
          ctrl.markPass = chkPass;
          ctrl.markFail = !chkPass;
          stateNext     = ST_STEP;
        end
      end
      ST_STEP: begin
        ctrl.timerClr = 1'b1;
        if (!lastTap) begin
          ctrl.advance = 1'b1;
          stateNext    = ST_APPLY;
        end else if (anyPass) begin
          ctrl.loadFinal = 1'b1;
          stateNext      = ST_FIN_APPLY;
        end else begin
          stateNext = ST_FAIL;
        end
      end
      ST_FIN_APPLY: begin
        if (tapReady)     stateNext = ST_OK;
        else if (timeout) stateNext = ST_FAIL;
      end
      ST_OK:   stateNext = ST_IDLE;
      ST_FAIL: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign tapUpdate = (state == ST_APPLY) || (state == ST_FIN_APPLY);
  assign chkReq    = (state == ST_CHECK);
  assign done      = (state == ST_OK) || (state == ST_FAIL);
  assign err       = (state == ST_FAIL);

endmodule

// File: rtl/tap_window_tuner.sv
module tap_window_tuner
  import tap_tune_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int TAP_COUNT   = 40,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       speedMode,
  output logic             done,
  output logic             err,
  output logic [TAP_W-1:0] tapValue,
  output logic             tapUpdate,
  input  logic             tapReady,
  output logic             chkReq,
  input  logic             chkAck,
  input  logic             chkPass
);

  tuneCtrl_t ctrl;
  logic      lastTap;
  logic      anyPass;
  logic      timeout;

  tap_tune_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .speedMode (speedMode),
    .tapReady  (tapReady),
    .chkAck    (chkAck),
    .chkPass   (chkPass),
    .lastTap   (lastTap),
    .anyPass   (anyPass),
    .timeout   (timeout),
    .ctrl      (ctrl),
    .tapUpdate (tapUpdate),
    .chkReq    (chkReq),
    .done      (done),
    .err       (err)
  );

  tap_tune_datapath #(
    .TAP_W       (TAP_W),
    .TAP_COUNT   (TAP_COUNT),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .tapIdx  (tapValue),
    .lastTap (lastTap),
    .anyPass (anyPass),
    .timeout (timeout)
  );

endmodule

// File: rtl/tap_tune_checker.sv
module tap_tune_checker #(
  parameter int TAP_W     = 6,
  parameter int TAP_COUNT = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic             done,
  input logic             err,
  input logic [TAP_W-1:0] tapValue,
  input logic             tapUpdate,
  input logic             tapReady,
  input logic             chkReq,
  input logic             chkAck
);

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(tapUpdate && chkReq)); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done); // R6

  AST_CHK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (chkReq && !chkAck) |=> chkReq); // R2

  AST_CHK_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chkReq) |-> $past(tapReady)); // R2

  AST_TAP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (tapUpdate && $past(tapUpdate) && $past(rstN)) |-> $stable(tapValue)); // R1

  AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tapUpdate |-> (tapValue < TAP_W'(TAP_COUNT))); // R1

endmodule

bind tap_window_tuner tap_tune_checker #(
  .TAP_W     (TAP_W),
  .TAP_COUNT (TAP_COUNT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .done      (done),
  .err       (err),
  .tapValue  (tapValue),
  .tapUpdate (tapUpdate),
  .tapReady  (tapReady),
  .chkReq    (chkReq),
  .chkAck    (chkAck)
);

// File: tb/tap_window_tuner_tb.sv
module tap_window_tuner_tb;

  localparam int TAP_W   = 6;
  localparam int NTAP    = 40;
  localparam int TMO     = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [2:0]       speedMode = 3'd4;
  logic             done, err, tapUpdate, chkReq;
  logic [TAP_W-1:0] tapValue;
  logic             tapReady = 1'b0;
  logic             chkAck = 1'b0;
  logic             chkPass = 1'b0;

  always #4 clk = ~clk;

  tap_window_tuner #(.TAP_W(TAP_W), .TAP_COUNT(NTAP), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .speedMode(speedMode),
    .done(done), .err(err), .tapValue(tapValue), .tapUpdate(tapUpdate),
    .tapReady(tapReady), .chkReq(chkReq), .chkAck(chkAck), .chkPass(chkPass)
  );

  int vecCnt = 0;
  int missCnt = 0;
  int cycles = 0;

  logic [NTAP-1:0] passMask;
  logic [NTAP-1:0] stallMask;

  int   tapLog [0:127];
  int   tapLogN;
  int   chkLog [0:127];
  int   chkLogN;
  int   doneCnt;
  logic doneErr;
  int   doneTap;
  int   updCycles;

  int tapWait = 0, tapLat = 0;
  int chkWait = 0, chkLat = 0;
  logic chkReqD = 1'b0;

  // delay-line model
  always @(negedge clk) begin
    cycles++;
    if (tapReady) tapReady <= 1'b0;
    else if (tapUpdate && !stallMask[tapValue]) begin
      if (tapWait >= tapLat) begin
        tapReady <= 1'b1;
        tapLog[tapLogN] = int'(tapValue);
        tapLogN++;
        tapWait = 0;
        tapLat = $urandom_range(0, 4);
      end else tapWait++;
    end else if (!tapUpdate) tapWait = 0;
    if (tapUpdate) updCycles++;
  end

  // tuning-check model
  always @(negedge clk) begin
    if (chkReq && !chkReqD) begin
      chkLog[chkLogN] = int'(tapValue);
      chkLogN++;
    end
    chkReqD <= chkReq;
    if (chkAck) chkAck <= 1'b0;
    else if (chkReq) begin
      if (chkWait >= chkLat) begin
        chkAck  <= 1'b1;
        chkPass <= passMask[tapValue];
        chkWait = 0;
        chkLat = $urandom_range(0, 5);
      end else chkWait++;
    end
  end

  // completion monitor
  always @(negedge clk) begin
    if (done) begin
      doneCnt++;
      doneErr = err;
      doneTap = int'(tapValue);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecCnt++;
    if (!ok) begin
      missCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void expectWindow(input logic [NTAP-1:0] pm, input logic [NTAP-1:0] sm,
                                       output int bestLen, output int finalTap);
    int cur = 0, best = 0, bEnd = 0;
    for (int t = 0; t < NTAP; t++) begin
      if (pm[t] && !sm[t]) begin
        cur++;
        if (cur > best) begin best = cur; bEnd = t; end
      end else cur = 0;
    end
    bestLen = best;
    finalTap = bEnd - best / 2;
  endfunction

  task automatic runSearch(input logic [NTAP-1:0] pm, input logic [NTAP-1:0] sm,
                           input bit midStart, input string tag);
    int expLen, expTap, k, guard;
    passMask = pm;
    stallMask = sm;
    tapLogN = 0; chkLogN = 0; doneCnt = 0; updCycles = 0;
    speedMode = 3'd4;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (midStart) begin
      repeat (50) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    guard = 0;
    while (doneCnt == 0 && guard < 4000) begin @(negedge clk); guard++; end
    if (guard >= 4000) check(1'b0, {tag, " R8 watchdog"}, 0, 1);
    repeat (30) @(negedge clk);
    expectWindow(pm, sm, expLen, expTap);
    // R1 / R3: confirmed taps in ascending order, stalled ones skipped
    k = 0;
    for (int t = 0; t < NTAP; t++) begin
      if (!sm[t]) begin
        check(k < tapLogN && tapLog[k] == t, {tag, " R1 tap order"}, (k < tapLogN) ? tapLog[k] : -1, t);
        k++;
      end
    end
    // R2 / R3: a check for every confirmed sweep tap, none for stalled taps
    check(chkLogN == k, {tag, " R3 check count"}, chkLogN, k);
    for (int j = 0; j < chkLogN; j++)
      check(!sm[chkLog[j]], {tag, " R3 check on stalled tap"}, chkLog[j], -1);
    check(doneCnt == 1, {tag, " R8 single done"}, doneCnt, 1);
    if (expLen == 0) begin
      check(doneErr == 1'b1, {tag, " R6 err"}, int'(doneErr), 1);
      check(tapLogN == k, {tag, " R6 no final update"}, tapLogN, k);
    end else begin
      check(doneErr == 1'b0, {tag, " R5 err low"}, int'(doneErr), 0);
      check(tapLogN == k + 1 && tapLog[k] == expTap, {tag, " R4 R5 final applied"},
            (tapLogN == k + 1) ? tapLog[k] : -1, expTap);
      check(doneTap == expTap, {tag, " R5 tap at done"}, doneTap, expTap);
    end
    check(tapUpdate == 1'b0 && chkReq == 1'b0, {tag, " R8 idle after done"}, int'(tapUpdate), 0);
  endtask

  task automatic runReject(input logic [2:0] mode);
    int guard;
    tapLogN = 0; chkLogN = 0; doneCnt = 0; updCycles = 0;
    speedMode = mode;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    guard = 0;
    while (doneCnt == 0 && guard < 20) begin @(negedge clk); guard++; end
    repeat (5) @(negedge clk);
    check(doneCnt == 1 && doneErr == 1'b1, "R7 reject done+err", doneCnt, 1);
    check(updCycles == 0 && chkLogN == 0, "R7 no update or check", updCycles + chkLogN, 0);
    speedMode = 3'd4;
  endtask

  initial begin
    logic [NTAP-1:0] pm, sm;
    void'($urandom(32'd20240611));
    passMask = '0; stallMask = '0;
    tapLogN = 0; chkLogN = 0; doneCnt = 0; updCycles = 0;
    doneErr = 1'b0; doneTap = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!done && !err && !tapUpdate && !chkReq && tapValue == '0, "R9 reset outputs",
          int'({done, err, tapUpdate, chkReq}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && !tapUpdate && !chkReq, "R9 idle after reset", int'({done, tapUpdate, chkReq}), 0);

    runReject(3'd0);
    runReject(3'd2);
    runReject(3'd3);
    runReject(3'd5);

    runSearch({NTAP{1'b1}}, '0, 1'b1, "allpass");
    runSearch('0, '0, 1'b0, "nopass");
    pm = '0; pm[5:2] = '1; pm[13:10] = '1;
    runSearch(pm, '0, 1'b1, "tie R4");
    pm = '0; pm[NTAP-1] = 1'b1;
    runSearch(pm, '0, 1'b0, "lastonly");
    pm = '0; pm[0] = 1'b1;
    runSearch(pm, '0, 1'b0, "firstonly");
    sm = '0; sm[20] = 1'b1;
    runSearch({NTAP{1'b1}}, sm, 1'b0, "stall R3");
    pm = '0; pm[8:3] = '1; pm[30:25] = '1; pm[31] = 1'b0;
    runSearch(pm, '0, 1'b0, "equal6");

    for (int r = 0; r < 20; r++) begin
      for (int t = 0; t < NTAP; t++) begin
        pm[t] = ($urandom_range(0, 99) < 70);
        sm[t] = ($urandom_range(0, 99) < 5);
      end
      runSearch(pm, sm, (r % 3) == 0, "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    check(1'b0, "R8 global watchdog", cycles, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule